// File: doc/BRIEF.md
# Serial Command Frame Transmitter

This block turns a register access request into one command frame on a serial link. The link has a single data line and a clock that the master drives. A request carries a target id, an address, a direction, an access width and write data, and is accepted through a valid/ready handshake. The block assembles a fixed-layout header and appends the write data when there is any. It then adds a 4-bit CRC and shifts the whole frame out MSB first, after a start bit. Every bit on the data line is inverted, so a logical 1 is driven low.

After each frame the block drives the line high for a fixed run of echo clocks and then goes idle. A second request type sends a short fixed data-poll code instead of an access frame. A direction-enable output tells the pad logic when the master owns the data line. Receiving the response is handled elsewhere.

Top module: `serial_cmd_tx`

## Requirements
- R1: The header is 28 bits, sent MSB first: target id in bits 27:26, command code in bits 25:22 (1000 for write, 1001 for read), address bits 20:0 in bits 21:1, and the size flag in bit 0.
- R2: `req_size` encodes the width (00 = 8 bits, 01 = 16 bits, 10 or 11 = 32 bits). An 8-bit access clears the size flag. A 16-bit access sets it. A 32-bit access sets it and also forces header bit 1 (the address LSB) to 1.
- R3: When `req_tid` is 00, the header target id is taken from `req_addr[22:21]` instead. Only `req_addr[20:0]` goes into the header.
- R4: A write appends 8, 16 or 32 bits of data after the header, MSB first, taken from the low bits of `req_wdata`. A read appends no data.
- R5: A 4-bit CRC follows the last header or data bit, MSB first. It uses polynomial x^4+x^2+x+1 and an initial value of 0, and covers a leading 1 followed by every header and data bit.
- R6: On the wire a logical-1 start bit comes first, then the frame. Each bit is driven inverted on `link_dout`.
- R7: Each bit occupies one link clock period. `link_clk` is high for HALF_CYCLES cycles and then low for HALF_CYCLES cycles. `link_dout` changes only at the start of a period, and only when the new bit differs from the previous one.
- R8: After the last frame bit, `link_dout` stays high for 16 more link clock periods. Then `link_oe` drops.
- R9: A request with `req_poll` set sends the 9-bit code 0x02A after a start bit. It adds no CRC and is followed by the echo periods. All other request fields are ignored.
- R10: `link_oe` rises in the cycle after acceptance, together with the start bit. It stays high through the echo periods. While idle, `link_oe` is low and both `link_clk` and `link_dout` are high.
- R11: `req_ready` is high only while idle. A request held valid while a frame is in flight is not taken and does not change the frame being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_poll | input | 1 | Send the data-poll code instead of an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_tid | input | 2 | Target id (00 = take it from the address) |
| req_addr | input | 23 | Access address |
| req_size | input | 2 | Access width code |
| req_wdata | input | 32 | Write data, right aligned |
| link_clk | output | 1 | Link clock, high when idle |
| link_dout | output | 1 | Data line value, active low |
| link_oe | output | 1 | Master drives the data line |

## Verification
Some rules are checked by the embedded assertions on every cycle. These are the idle line levels, the start bit following acceptance, and data changing only at a period boundary. They also cover the line staying high during the echo periods, ready being low while the line is owned, and each period ending with the clock low. Header layout, size and id substitution, data placement, CRC value, frame length and the echo count can only be seen by the bench's directed frames. The bench captures each link clock period and compares the decoded bits against a frame it builds independently. The same holds for a request held pending during a busy frame being ignored.

// File: rtl/sct_pkg.sv
package sct_pkg;
    localparam int TID_W      = 2;
    localparam int ADDR_W     = 23;
    localparam int HDR_ADDR_W = 21;
    localparam int HDR_W      = TID_W + 4 + HDR_ADDR_W + 1;
    localparam int DATA_W     = 32;
    localparam int CRC_W      = 4;
    localparam int BODY_MAX   = HDR_W + DATA_W;
    localparam int FRAME_MAX  = 1 + BODY_MAX + CRC_W;
    localparam int LEN_W      = $clog2(FRAME_MAX + 1);
    localparam int ECHO_SLOTS = 16;
    localparam int POLL_W     = 9;

    localparam logic [3:0]        CMD_WR    = 4'b1000;
    localparam logic [3:0]        CMD_RD    = 4'b1001;
    localparam logic [POLL_W-1:0] POLL_CODE = 9'h02A;
    localparam logic [CRC_W-1:0]  CRC_POLY  = 4'b0111;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WRD2 = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_SEND = 2'b01,
        ST_ECHO = 2'b10
    } tx_state_e;

    typedef struct packed {
        logic [TID_W-1:0]      tid;
        logic [3:0]            cmd;
        logic [HDR_ADDR_W-1:0] addr;
        logic                  size_flag;
    } hdr_t;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;
        logic [LEN_W-1:0]     len;
    } frame_t;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction
endpackage

// File: rtl/sct_frame_builder.sv
module sct_frame_builder
    import sct_pkg::*;
(
    input  logic              poll,
    input  logic              write,
    input  logic [TID_W-1:0]  tid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] wdata,
    output frame_t            frame
);
    localparam int BL_W = $clog2(BODY_MAX + 1);

    hdr_t                hdr;
    logic [BODY_MAX-1:0] body;
    logic [BL_W-1:0]     dlen;
    logic [BL_W-1:0]     blen;
    logic [CRC_W-1:0]    crc;

    always_comb begin
        hdr.tid       = (tid == '0) ? addr[ADDR_W-1 -: TID_W] : tid;
        hdr.cmd       = write ? CMD_WR : CMD_RD;
        hdr.addr      = addr[HDR_ADDR_W-1:0];
        hdr.size_flag = 1'b0;
        body          = '0;
        dlen          = '0;
        case (acc_size_e'(size))
            SZ_BYTE: begin
                if (write) begin
                    dlen = BL_W'(8);
                    body[DATA_W-1 -: 8] = wdata[7:0];
                end
            end
            SZ_HALF: begin
                hdr.size_flag = 1'b1;
                if (write) begin
                    dlen = BL_W'(16);
                    body[DATA_W-1 -: 16] = wdata[15:0];
                end
            end
            default: begin
                hdr.size_flag = 1'b1;
                hdr.addr[0]   = 1'b1;
                if (write) begin
                    dlen = BL_W'(DATA_W);
                    body[DATA_W-1:0] = wdata;
                end
            end
        endcase
        body[BODY_MAX-1 -: HDR_W] = hdr;
        blen = BL_W'(HDR_W) + dlen;

        crc = crc_step('0, 1'b1);
        for (int i = 0; i < BODY_MAX; i++) begin
            if (BL_W'(i) < blen) crc = crc_step(crc, body[BODY_MAX-1-i]);
        end

        if (poll) begin
            frame.bits = {1'b1, POLL_CODE, {(FRAME_MAX-1-POLL_W){1'b0}}};
            frame.len  = LEN_W'(1 + POLL_W);
        end else begin
            frame.bits = {1'b1, body, {CRC_W{1'b0}}}
                       | ({{(FRAME_MAX-CRC_W){1'b0}}, crc} << (BL_W'(BODY_MAX) - blen));
            frame.len  = LEN_W'(1 + CRC_W) + LEN_W'(blen);
        end
    end
endmodule

// File: rtl/sct_bit_timer.sv
module sct_bit_timer #(
    parameter int HALF_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic lclk,
    output logic slot_end
);
    localparam int SLOT = 2 * HALF_CYCLES;
    localparam int CW   = $clog2(SLOT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == CW'(SLOT - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign lclk     = !run || (cnt < CW'(HALF_CYCLES));
    assign slot_end = run && (cnt == CW'(SLOT - 1));

    // R7: a bit period closes while the link clock is in its low phase
    p_slot_ends_low_r7: assert property (@(posedge clk) disable iff (rst)
        slot_end |-> !lclk);
    // R10: the clock rests high when no frame is running
    p_idle_clk_high_r10: assert property (@(posedge clk) disable iff (rst)
        !run |-> lclk);
endmodule

// File: rtl/sct_serializer.sv
module sct_serializer
    import sct_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  frame_t frame,
    input  logic   slot_end,
    output logic   run,
    output logic   idle,
    output logic   dout
);
    localparam int EW = $clog2(ECHO_SLOTS);

    tx_state_e            state;
    logic [FRAME_MAX-1:0] shreg;
    logic [LEN_W-1:0]     left;
    logic [EW-1:0]        echo_left;
    logic                 next_wire;

    assign next_wire = ~shreg[FRAME_MAX-1];
    assign run       = (state != ST_IDLE);
    assign idle      = (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            shreg     <= '0;
            left      <= '0;
            echo_left <= '0;
            dout      <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        shreg <= frame.bits << 1;
                        left  <= frame.len - 1'b1;
                        if (dout != ~frame.bits[FRAME_MAX-1]) dout <= ~frame.bits[FRAME_MAX-1];
                        state <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (slot_end) begin
                        if (left != '0) begin
                            if (next_wire != dout) dout <= next_wire;
                            shreg <= shreg << 1;
                            left  <= left - 1'b1;
                        end else begin
                            dout      <= 1'b1;
                            echo_left <= EW'(ECHO_SLOTS - 1);
                            state     <= ST_ECHO;
                        end
                    end
                end
                ST_ECHO: begin
                    if (slot_end) begin
                        if (echo_left == '0) state <= ST_IDLE;
                        else echo_left <= echo_left - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6: acceptance is followed by the inverted start bit on the line
    p_start_bit_low_r6: assert property (@(posedge clk) disable iff (rst)
        (start && idle) |=> (!dout && run));
    // R7: the data line moves only at a bit period boundary
    p_dout_at_boundary_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && run && (dout != $past(dout))) |-> $past(slot_end));
    // R8: the line is held high through the echo periods
    p_echo_high_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ECHO) |-> dout);
endmodule

// File: rtl/serial_cmd_tx.sv
module serial_cmd_tx
    import sct_pkg::*;
#(
    parameter int HALF_CYCLES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_poll,
    input  logic        req_write,
    input  logic [1:0]  req_tid,
    input  logic [22:0] req_addr,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_wdata,
    output logic        link_clk,
    output logic        link_dout,
    output logic        link_oe
);
    frame_t frame;
    logic   run;
    logic   idle;
    logic   slot_end;
    logic   accept;

    sct_frame_builder u_build (
        .poll  (req_poll),
        .write (req_write),
        .tid   (req_tid),
        .addr  (req_addr),
        .size  (req_size),
        .wdata (req_wdata),
        .frame (frame)
    );

    sct_bit_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .lclk     (link_clk),
        .slot_end (slot_end)
    );

    sct_serializer u_ser (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .frame    (frame),
        .slot_end (slot_end),
        .run      (run),
        .idle     (idle),
        .dout     (link_dout)
    );

    assign req_ready = idle;
    assign accept    = req_valid && req_ready;
    assign link_oe   = run;

    // R10: with the line released, clock and data rest high
    p_idle_line_r10: assert property (@(posedge clk) disable iff (rst)
        !link_oe |-> (link_dout && link_clk));
    // R11: no request is taken while the line is owned
    p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (rst)
        link_oe |-> !req_ready);
endmodule

// File: tb/test_serial_cmd_tx.sv
module test_serial_cmd_tx;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int ECHO       = 16;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_poll = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_tid = '0;
    logic [22:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        link_clk;
    logic        link_dout;
    logic        link_oe;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    logic cap [0:127];
    int   ncap = 0;
    int   fall_t [0:3];
    logic prev_lclk = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_cmd_tx #(.HALF_CYCLES(HALF)) i_serial_cmd_tx (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_poll(req_poll), .req_write(req_write), .req_tid(req_tid),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .link_clk(link_clk), .link_dout(link_dout), .link_oe(link_oe)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (link_oe && prev_lclk && !link_clk && ncap < 128) begin
            if (ncap < 4) fall_t[ncap] = cyc;
            cap[ncap] = link_dout;
            ncap = ncap + 1;
        end
        prev_lclk = link_clk;
    end

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Independent frame model: returns logical frame bits right aligned, start bit included
    function automatic logic [127:0] model(input logic poll, input logic w, input logic [1:0] tid,
                                           input logic [22:0] addr, input logic [1:0] sz,
                                           input logic [31:0] wd, output int len);
        logic [1:0]   t;
        logic [20:0]  a;
        logic         sf;
        logic [27:0]  hdr;
        logic [127:0] m;
        logic [127:0] r;
        int           dn;
        int           mlen;
        if (poll) begin
            len = 10;
            return 128'({1'b1, 9'h02A});
        end
        t  = (tid == 2'b00) ? addr[22:21] : tid;
        a  = addr[20:0];
        sf = (sz != 2'b00);
        if (sz[1]) a[0] = 1'b1;
        hdr = {t, 3'b100, ~w, a, sf};
        dn  = !w ? 0 : (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        m   = 128'(hdr);
        if (dn == 8)  m = (m << 8)  | 128'(wd[7:0]);
        if (dn == 16) m = (m << 16) | 128'(wd[15:0]);
        if (dn == 32) m = (m << 32) | 128'(wd);
        mlen = 29 + dn;
        m    = m | (128'(1) << (mlen - 1));
        r    = m << 4;
        for (int i = mlen + 3; i >= 4; i--) begin
            if (r[i]) r = r ^ (128'(5'b10111) << (i - 4));
        end
        len = mlen + 4;
        return (m << 4) | 128'(r[3:0]);
    endfunction

    task automatic run_frame(input logic poll, input logic w, input logic [1:0] tid,
                             input logic [22:0] addr, input logic [1:0] sz,
                             input logic [31:0] wd, input string tag, input bit hold_busy);
        int           len;
        logic [127:0] lf;
        logic [127:0] expw;
        logic [127:0] actw;
        lf = model(poll, w, tid, addr, sz, wd, len);
        @(negedge clk);
        ncap = 0;
        req_poll = poll; req_write = w; req_tid = tid; req_addr = addr;
        req_size = sz; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        // R10 R6: line owned and start bit (driven low) right after acceptance
        check(link_oe && !link_dout, {tag, " R10 R6 start"}, {link_oe, link_dout}, 2'b10);
        if (hold_busy) begin
            req_valid = 1'b1; req_poll = 1'b1; req_write = 1'b1; req_tid = 2'b11;
            repeat (20) @(negedge clk);
            // R11: request held during a frame is not taken
            check(!req_ready, {tag, " R11 ready low while busy"}, 128'(req_ready), 0);
            req_valid = 1'b0;
        end
        while (link_oe) @(negedge clk);
        expw = '0;
        actw = '0;
        for (int i = 0; i < len; i++) expw = {expw[126:0], ~lf[len-1-i]};
        for (int i = 0; i < ECHO; i++) expw = {expw[126:0], 1'b1};
        for (int i = 0; i < ncap; i++) actw = {actw[126:0], cap[i]};
        // R8: frame bits plus exactly 16 echo periods
        check(ncap == len + ECHO, {tag, " R8 period count"}, 128'(ncap), 128'(len + ECHO));
        // R1 R2 R3 R4 R5 R6 R9: wire content, inverted, MSB first
        check(actw == expw, {tag, " R1 R2 R3 R4 R5 R6 R9 wire bits"}, actw, expw);
        // R7: one link clock period per bit
        check(fall_t[1] - fall_t[0] == 2 * HALF, {tag, " R7 period"},
              128'(fall_t[1] - fall_t[0]), 128'(2 * HALF));
        if (hold_busy) begin
            repeat (10) @(negedge clk);
            check(!link_oe && req_ready, {tag, " R11 no late start"}, {link_oe, req_ready}, 2'b01);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: idle line after reset
        check(req_ready && !link_oe && link_clk && link_dout, "reset R10 idle",
              {req_ready, link_oe, link_clk, link_dout}, 4'b1011);

        run_frame(1'b0, 1'b1, 2'b01, 23'h0A5A5A, 2'b00, 32'hFFFF_FF3C, "wr8 R4", 1'b0);
        run_frame(1'b0, 1'b1, 2'b10, 23'h012344, 2'b01, 32'h0000_BEEF, "wr16 R2", 1'b0);
        run_frame(1'b0, 1'b1, 2'b11, 23'h1FFFFE, 2'b10, 32'hDEAD_BEEF, "wr32 R2", 1'b0);
        run_frame(1'b0, 1'b0, 2'b01, 23'h000100, 2'b00, 32'h1234_5678, "rd8 R4", 1'b0);
        run_frame(1'b0, 1'b0, 2'b00, 23'h5ABCD2, 2'b11, 32'h0, "rd32 tid0 R3", 1'b0);
        run_frame(1'b0, 1'b1, 2'b00, 23'h3FFFFF, 2'b01, 32'h0000_8001, "wr16 tid0 R3", 1'b0);
        run_frame(1'b1, 1'b1, 2'b11, 23'h7FFFFF, 2'b10, 32'hFFFF_FFFF, "poll R9", 1'b0);
        run_frame(1'b0, 1'b1, 2'b10, 23'h2AAAAA, 2'b10, 32'h0F0F_0F0F, "busy R11", 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule